// File: doc/BRIEF.md
# Power-Gated Memory Bank Controller

This block wraps a 256-row by 256-bit storage array with the control needed to keep it mostly switched off. A network-interface front end hands it one request at a time over a valid/ready handshake. A request is either a 32-bit write into one 32-bit lane of a row, or a read of 32, 64, 128 or 256 bits taken from a row. The array is treated as four 128x128 quadrants. A read of 128 bits or less must stay inside one column half, so only one quadrant's sense path is used.

Two gating policies are selected through a small configuration port. Under the cell-only policy the peripheral circuits stay powered, and the block is always ready. Under the full policy the peripherals sit in OFF while idle. A request wakes them through a WAKING phase whose length is set in clock cycles. The request is held by deasserting ready and is never dropped. The block returns to OFF as soon as a serviced command leaves nothing behind it. In either policy only the row being accessed has its cell enable (power line and word line) raised, and every other row stays gated.

The current power state, the configured wake delay and a running count of ON cycles are visible at the ports. The count lets a testbench estimate energy.

Top module: `pgm_bank`

## Requirements
- R1: While reset is high, and until the first request or configuration write after it, the outputs are: pwr_state OFF, policy full, wake_dly 4, req_ready 0, rsp_valid 0, row_en 0 and on_cycles 0.
- R2: A cycle with cfg_we high loads the policy bit (1 = full, 0 = cell-only) and the 4-bit wake delay. wake_dly shows the new delay from the next cycle on.
- R3: pwr_state is encoded OFF=0, WAKING=1 and ON=2. Under the full policy, a request seen in OFF causes WAKING for exactly wake_dly cycles, with no WAKING when the delay is 0, and then ON. req_ready is high only in ON, so the request waits 1+wake_dly cycles.
- R4: Under the full policy, a cycle in ON with req_valid low is followed by OFF. Back-to-back requests keep the state ON with no stall.
- R5: Under the cell-only policy, pwr_state is ON from the cycle after the policy takes effect. It never shows WAKING, and requests are accepted without stall.
- R6: An accepted write with size code 0 stores req_wdata into bits [32*lane +: 32] of the addressed row and leaves every other bit of the array unchanged. The next cycle shows rsp_valid=1 and rsp_err=0.
- R7: An accepted write with a size code other than 0 (wider than 32 bits) is rejected: rsp_err=1 in the response cycle and the array is unchanged.
- R8: Read size codes 0, 1, 2 and 3 select 32, 64, 128 and 256 bits. One cycle after acceptance, rsp_data holds the row bits starting at bit 32*lane, right-aligned, with zeros above the requested width.
- R9: A read with size code 0 to 2 is legal only if (lane mod 4) plus its lane count is at most 4. A 256-bit read is legal only with lane 0. An illegal read gives rsp_err=1 and rsp_data=0.
- R10: In the response cycle of a legal request, row_en is one-hot at the accessed row. In every other cycle, including after a rejected request, row_en is all zero.
- R11: on_cycles increases by one for each clock cycle spent in ON and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load configuration this cycle |
| cfg_full_pg | input | 1 | Policy: 1 full gating, 0 cell-only |
| cfg_wake_dly | input | 4 | Wake-up delay in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_row | input | 8 | Row address |
| req_lane | input | 3 | Starting 32-bit lane |
| req_size | input | 2 | Width code: 32/64/128/256 bits |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle of an accepted request |
| rsp_err | output | 1 | Request was rejected |
| rsp_data | output | 256 | Read data, right-aligned |
| row_en | output | 256 | Per-row cell enable |
| pwr_state | output | 2 | Peripheral power state |
| wake_dly | output | 4 | Configured wake delay |
| on_cycles | output | 32 | Cycles spent in ON |

## Verification
Directed accesses check the wake-up sequence with delays of 0, 3 and 15, and compare the stall length with the configured delay. They also compare back-to-back requests against isolated ones, which separates the stay-on path from the return-to-OFF path. Reads at every lane and size boundary, such as lane 2 versus lane 3 at 64 bits and lane 0 versus lane 1 at 256 bits, separate the quadrant rule from plain alignment. A rejected wide write followed by a full-row read shows that the array was untouched. A seeded random mix of writes, reads of all widths and policy switches is then checked against a bench model of the array, which exposes lane-placement and masking faults.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [1:0] {
    PS_OFF    = 2'd0,
    PS_WAKING = 2'd1,
    PS_ON     = 2'd2
  } pwr_e;
endpackage

// File: rtl/pgm_power_fsm.sv
module pgm_power_fsm
  import pgm_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             full_pg,
  input  logic [DLY_W-1:0] dly,
  input  logic             req_valid,
  output pwr_e             state,
  output logic             ready
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_OFF;
      cnt   <= '0;
    end else if (!full_pg) begin
      state <= PS_ON;
    end else begin
      case (state)
        PS_OFF: if (req_valid) begin
          if (dly == '0) state <= PS_ON;
          else begin
            state <= PS_WAKING;
            cnt   <= dly - 1'b1;
          end
        end
        PS_WAKING: begin
          if (cnt == '0) state <= PS_ON;
          else cnt <= cnt - 1'b1;
        end
        PS_ON: if (!req_valid) state <= PS_OFF;
        default: state <= PS_OFF;
      endcase
    end
  end

  assign ready = (state == PS_ON);
endmodule

// File: rtl/pgm_req_check.sv
module pgm_req_check #(
  parameter int LANES = 8,
  parameter int LANE_W = 3,
  parameter int SZ_W = 2
) (
  input  logic              write,
  input  logic [LANE_W-1:0] lane,
  input  logic [SZ_W-1:0]   size,
  output logic              ok
);
  localparam int HALF = LANES / 2;

  int n;
  int lane_in_half;

  always_comb begin
    n = 1 << size;
    lane_in_half = int'(lane) % HALF;
    if (write)           ok = (size == '0);
    else if (n == LANES) ok = (lane == '0);
    else if (n > LANES)  ok = 1'b0;
    else                 ok = (lane_in_half + n) <= HALF;
  end
endmodule

// File: rtl/pgm_lane_array.sv
module pgm_lane_array #(
  parameter int ROWS = 256,
  parameter int BITS = 32,
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [BITS-1:0] wdata,
  output logic [BITS-1:0] rdata
);
  logic [BITS-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/pgm_bank.sv
module pgm_bank
  import pgm_pkg::*;
#(
  parameter int ROWS    = 256,
  parameter int WIDTH   = 256,
  parameter int WR_BITS = 32,
  parameter int DLY_W   = 4,
  parameter int CNT_W   = 32,
  parameter int RST_DLY = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic                         cfg_full_pg,
  input  logic [DLY_W-1:0]             cfg_wake_dly,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [$clog2(ROWS)-1:0]      req_row,
  input  logic [$clog2(WIDTH/WR_BITS)-1:0] req_lane,
  input  logic [$clog2($clog2(WIDTH/WR_BITS)+1)-1:0] req_size,
  input  logic [WR_BITS-1:0]           req_wdata,
  output logic                         rsp_valid,
  output logic                         rsp_err,
  output logic [WIDTH-1:0]             rsp_data,
  output logic [ROWS-1:0]              row_en,
  output logic [1:0]                   pwr_state,
  output logic [DLY_W-1:0]             wake_dly,
  output logic [CNT_W-1:0]             on_cycles
);
  localparam int LANES  = WIDTH / WR_BITS;
  localparam int LANE_W = $clog2(LANES);
  localparam int SZ_W   = $clog2(LANE_W + 1);
  localparam int AW     = $clog2(ROWS);

  logic             pol_q;
  logic [DLY_W-1:0] dly_q;
  pwr_e             fsm_state;
  logic             acc, ok;
  logic             rd_ok_q;
  logic [LANE_W-1:0] lane_q;
  logic [SZ_W-1:0]   size_q;
  logic [WIDTH-1:0]  row_q, shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= 1'b1;
      dly_q <= DLY_W'(RST_DLY);
    end else if (cfg_we) begin
      pol_q <= cfg_full_pg;
      dly_q <= cfg_wake_dly;
    end
  end

  pgm_power_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk(clk), .rst(rst), .full_pg(pol_q), .dly(dly_q),
    .req_valid(req_valid), .state(fsm_state), .ready(req_ready)
  );

  pgm_req_check #(.LANES(LANES), .LANE_W(LANE_W), .SZ_W(SZ_W)) u_chk_req (
    .write(req_write), .lane(req_lane), .size(req_size), .ok(ok)
  );

  assign acc = req_valid && req_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pgm_lane_array #(.ROWS(ROWS), .BITS(WR_BITS), .AW(AW)) u_lane (
      .clk(clk),
      .we(acc && ok && req_write && (req_lane == LANE_W'(g))),
      .addr(req_row),
      .wdata(req_wdata),
      .rdata(row_q[g*WR_BITS +: WR_BITS])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rd_ok_q   <= 1'b0;
      row_en    <= '0;
      lane_q    <= '0;
      size_q    <= '0;
      on_cycles <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_err   <= acc && !ok;
      rd_ok_q   <= acc && ok && !req_write;
      row_en    <= (acc && ok) ? (ROWS'(1) << req_row) : '0;
      if (acc) begin
        lane_q <= req_lane;
        size_q <= req_size;
      end
      if (fsm_state == PS_ON) on_cycles <= on_cycles + 1'b1;
    end
  end

  assign shifted = row_q >> (int'(lane_q) * WR_BITS);

  always_comb begin
    for (int i = 0; i < LANES; i++)
      rsp_data[i*WR_BITS +: WR_BITS] =
        (rd_ok_q && (i < (1 << size_q))) ? shifted[i*WR_BITS +: WR_BITS] : '0;
  end

  assign pwr_state = 2'(fsm_state);
  assign wake_dly  = dly_q;
endmodule

// File: rtl/pgm_bank_chk.sv
module pgm_bank_chk #(
  parameter int ROWS  = 256,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [ROWS-1:0]  row_en,
  input logic [1:0]       pwr_state,
  input logic             pol_q,
  input logic             cfg_we,
  input logic [CNT_W-1:0] on_cycles
);
  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_en)); // R10
  AST_ERR_NO_ROW: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (row_en == '0)); // R10
  AST_ROW_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
    (row_en != '0) |-> rsp_valid); // R10
  AST_READY_ONLY_ON: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (pwr_state == 2'd2)); // R3
  AST_RSP_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready)); // R3
  AST_IDLE_TO_OFF: assert property (@(posedge clk) disable iff (rst)
    (pol_q && pwr_state == 2'd2 && !req_valid && !cfg_we) |=> (pwr_state == 2'd0)); // R4
  AST_CELL_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    $past(!pol_q) |-> (pwr_state != 2'd1)); // R5
  AST_ON_COUNT: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd2) |=> (on_cycles == CNT_W'($past(on_cycles) + 1'b1))); // R11
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != 2'd2) |=> $stable(on_cycles)); // R11
endmodule

bind pgm_bank pgm_bank_chk #(.ROWS(ROWS), .CNT_W(CNT_W)) u_bank_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .row_en(row_en),
  .pwr_state(pwr_state), .pol_q(pol_q), .cfg_we(cfg_we), .on_cycles(on_cycles)
);

// File: tb/pgm_bank_tb.sv
module pgm_bank_tb;
  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_full_pg = 0;
  logic [3:0] cfg_wake_dly = 0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [7:0] req_row = 0;
  logic [2:0] req_lane = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, rsp_err;
  logic [255:0] rsp_data, row_en;
  logic [1:0] pwr_state;
  logic [3:0] wake_dly;
  logic [31:0] on_cycles;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [255:0] mdl [256];
  int unsigned exp_on = 0;
  int stalls, wakes;

  always #2 clk = ~clk;

  pgm_bank u_dut (.*);

  always @(posedge clk) begin
    if (rst) exp_on = 0;
    else if (pwr_state == 2'd2) exp_on++;
  end

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit legal(input bit wr, input int lane, input int size);
    int n = 1 << size;
    if (wr) return size == 0;
    if (n == 8) return lane == 0;
    return (lane % 4) + n <= 4;
  endfunction

  function automatic logic [255:0] exp_rd(input int row, input int lane, input int size);
    logic [255:0] s = mdl[row] >> (lane * 32);
    logic [255:0] r = '0;
    for (int i = 0; i < (1 << size); i++) r[i*32 +: 32] = s[i*32 +: 32];
    return r;
  endfunction

  task automatic cfg(input bit pol, input int dly);
    cfg_we = 1; cfg_full_pg = pol; cfg_wake_dly = 4'(dly);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input bit wr, input int row, input int lane, input int size,
                        input logic [31:0] wd, input string tag);
    bit ok = legal(wr, lane, size);
    logic [255:0] exp;
    req_valid = 1; req_write = wr; req_row = 8'(row); req_lane = 3'(lane);
    req_size = 2'(size); req_wdata = wd;
    stalls = 0; wakes = 0;
    while (!req_ready) begin
      stalls++;
      if (pwr_state == 2'd1) wakes++;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
    if (wr && ok) mdl[row][lane*32 +: 32] = wd;
    exp = (!wr && ok) ? exp_rd(row, lane, size) : '0;
    chk({tag, " rsp_valid"}, 256'(rsp_valid), 256'(1));
    chk({tag, " rsp_err"}, 256'(rsp_err), 256'(!ok));
    if (!wr) chk({tag, " rsp_data"}, rsp_data, exp);
    chk({tag, " row_en R10"}, row_en, ok ? (256'(1) << row) : '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    // R1 reset values
    chk("R1 pwr_state", 256'(pwr_state), 256'(0));
    chk("R1 wake_dly", 256'(wake_dly), 256'(4));
    chk("R1 ready", 256'(req_ready), 256'(0));
    chk("R1 rsp_valid", 256'(rsp_valid), 256'(0));
    chk("R1 row_en", row_en, '0);
    chk("R1 on_cycles", 256'(on_cycles), 256'(0));
    rst = 0;
    idle(3);
    chk("R1 idle stays OFF", 256'(pwr_state), 256'(0));

    // R5 cell-only
    cfg(0, 4);
    idle(1);
    chk("R5 ON after policy", 256'(pwr_state), 256'(2));
    for (int r = 0; r < 17; r++) begin
      int row = (r == 16) ? 255 : r;
      for (int l = 0; l < 8; l++) access(1, row, l, 0, $urandom, "R6 init write");
    end
    access(0, 3, 0, 3, 0, "R8 cell-only full read");
    chk("R5 no stall", 256'(stalls), 256'(0));
    chk("R5 no waking", 256'(wakes), 256'(0));

    // R2 / R3 / R4 full policy with delay 3
    cfg(1, 3);
    chk("R2 wake_dly", 256'(wake_dly), 256'(3));
    idle(2);
    chk("R4 OFF when idle", 256'(pwr_state), 256'(0));
    access(0, 5, 2, 1, 0, "R9 lane2 64b legal");
    chk("R3 stall 1+dly", 256'(stalls), 256'(4));
    chk("R3 waking cycles", 256'(wakes), 256'(3));
    access(0, 5, 4, 2, 0, "R9 lane4 128b legal");
    chk("R4 back-to-back no stall", 256'(stalls), 256'(0));
    idle(1);
    chk("R4 OFF after command", 256'(pwr_state), 256'(0));

    cfg(1, 0);
    idle(1);
    access(0, 7, 1, 0, 0, "R8 32b read");
    chk("R3 dly0 stall", 256'(stalls), 256'(1));
    chk("R3 dly0 no waking", 256'(wakes), 256'(0));
    cfg(1, 15);
    idle(1);
    access(0, 9, 0, 2, 0, "R8 128b read");
    chk("R3 dly15 stall", 256'(stalls), 256'(16));

    // R9 quadrant rule, R7 wide write
    cfg(0, 2);
    idle(1);
    access(0, 2, 3, 1, 0, "R9 lane3 64b illegal");
    access(0, 2, 2, 2, 0, "R9 lane2 128b illegal");
    access(0, 2, 1, 3, 0, "R9 lane1 256b illegal");
    access(0, 2, 0, 3, 0, "R9 lane0 256b legal");
    access(1, 4, 0, 1, 32'hdead_beef, "R7 wide write rejected");
    access(0, 4, 0, 3, 0, "R7 row unchanged");
    access(1, 255, 7, 0, 32'hcafe_f00d, "R6 write row255 lane7");
    access(0, 255, 0, 3, 0, "R6 readback row255");
    chk("R6 top lane", 256'(rsp_data[255:224]), 256'(32'hcafe_f00d));
    chk("R11 on_cycles", 256'(on_cycles), 256'(exp_on));

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op = $urandom % 16;
      if (op == 0) begin
        cfg($urandom % 2, $urandom % 4);
        idle($urandom % 2);
      end else if (op < 6) begin
        access(1, $urandom % 16, $urandom % 8, ($urandom % 4 == 0) ? 1 : 0,
               $urandom, "R6 random write");
      end else begin
        access(0, $urandom % 16, $urandom % 8, $urandom % 4, 0, "R8 random read");
      end
      if ($urandom % 4 == 0) idle(1);
    end
    chk("R11 on_cycles end", 256'(on_cycles), 256'(exp_on));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule